// File: doc/BRIEF.md
# Privileged Register Window Access Unit

This unit sits between a processor's load/store path and its external bus port, and it inspects every word request. A request whose address falls in the top 16 MB of the address space (0xFF00_0000 and up) is served from a small set of eight internal 32-bit registers and never appears on the external bus. Any other address is passed to the external bus request port without change, and the answer from that port is handed back on the same response channel.

Inside the window, the unit checks privilege and access rights for each register. The lower 32 KB of the window is open to user mode, and the rest needs supervisor mode. Each register also states whether it can be read, written or updated atomically. A request that breaks any of these rules is refused with a fault strobe. Only the interrupt-pending and interrupt-mask registers accept the two atomic operations. Breakpoint registers can be written by a store, but only a separate system-control port can read them. That port can also read or apply a masked write to any of the eight registers, with no checks.

Each register takes a parameterised number of cycles to answer, 1 or 3. While a request is in flight, the unit accepts nothing new. A store or atomic update is therefore fully written before the next request is taken, and an atomic operation cannot be split by another access.

Top module: `mmr_access_unit`

## Requirements
- R1: A request with address bits [31:24] equal to 0xFF never raises `ext_req_valid`. Any other request is forwarded with the same address, op, write data and mask. `ext_req_valid` is held until `ext_req_ready`, and `ext_rdata` is returned on `rsp_rdata` when `ext_rsp_valid` arrives, with `rsp_fault` low.
- R2: Window offsets below 0x8000 are user space and open to either mode. With `req_super` low, a request at offset 0x8000 or above is refused. Register offsets: user scratch 0x0000 and 0x0004; interrupt pending 0x8000; interrupt mask 0x8004; breakpoints 0x8010 and 0x8014; control 0x8020 and 0x8024.
- R3: The following are refused: a load (op 0) from either breakpoint, a store (op 1) to the control register at 0x8024 (which is read-only), and any window offset that is not listed in R2, including offsets that are not word-aligned.
- R4: A refused request gives exactly one cycle of `rsp_valid` together with `rsp_fault`, returns zero data, and leaves every register unchanged.
- R5: An atomic modify (op 2) to interrupt pending or interrupt mask writes (`req_wdata` AND `req_mask`) OR (old AND NOT `req_mask`) and returns the old value.
- R6: An atomic add (op 3) to interrupt pending or interrupt mask writes old + `req_wdata` (modulo 2^32) and returns the old value.
- R7: An atomic modify or atomic add to any other internal register is refused.
- R8: Registers in `SLOW_SET` (by default the two control registers) give `rsp_valid` 3 cycles after the accepting edge. All other registers give it 1 cycle after. `req_ready` stays low from acceptance until the response cycle ends, and a store returns zero data.
- R9: The system-control port can read any register, breakpoints included. When `sys_write` is set, it writes (`sys_wdata` AND `sys_mask`) OR (old AND NOT `sys_mask`) and returns the old value. It answers only on `sys_rsp_valid`, never on `rsp_valid`, and when both ports ask in the same idle cycle it wins.
- R10: After reset, all registers read zero, `req_ready` is high, and no response or external request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load/store request present |
| req_ready | output | 1 | Request accepted on this edge |
| req_addr | input | 32 | Word address |
| req_op | input | 2 | 0 load, 1 store, 2 atomic modify, 3 atomic add |
| req_super | input | 1 | Requester is in supervisor mode |
| req_wdata | input | 32 | Store data or atomic operand |
| req_mask | input | 32 | Bit mask for atomic modify |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_rdata | output | 32 | Read or old value |
| rsp_fault | output | 1 | Request was refused |
| sys_valid | input | 1 | System-control request present |
| sys_ready | output | 1 | System-control request accepted |
| sys_write | input | 1 | Apply masked write |
| sys_idx | input | 3 | Register index (order of R2 offsets) |
| sys_wdata | input | 32 | Write data |
| sys_mask | input | 32 | Write mask |
| sys_rsp_valid | output | 1 | System-control response |
| sys_rdata | output | 32 | Old register value |
| ext_req_valid | output | 1 | External bus request |
| ext_req_ready | input | 1 | External bus took the request |
| ext_addr | output | 32 | Forwarded address |
| ext_op | output | 2 | Forwarded op |
| ext_wdata | output | 32 | Forwarded data |
| ext_mask | output | 32 | Forwarded mask |
| ext_rsp_valid | input | 1 | External response |
| ext_rdata | input | 32 | External response data |

## Verification
The properties assume the external bus side follows its handshake: `ext_rsp_valid` arrives only after `ext_req_ready` has accepted a request, and never while no request is open. The bench's bus model gives one ready pulse for each request and a single response three cycles later, so it never answers unprompted. The properties also assume that requesters keep their inputs steady until acceptance. The bench drives every input on the falling edge and holds it until it sees the ready signal.

// File: rtl/mmr_pkg.sv
package mmr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int NREG   = 8;
    localparam int IDX_W  = $clog2(NREG);
    localparam logic [7:0] WIN_TAG = 8'hFF;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_ATMOD = 2'd2,
        OP_ATADD = 2'd3
    } mmr_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSY,
        ST_FAULT,
        ST_EXT_REQ,
        ST_EXT_WAIT
    } unit_state_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic             super_only;
        logic             can_rd;
        logic             can_wr;
        logic             can_atomic;
    } reg_attr_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        mmr_op_e           op;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] mask;
        logic [IDX_W-1:0]  idx;
        logic              from_sys;
    } job_t;

    // Offset within window -> register attributes
    function automatic reg_attr_t lookup(input logic [23:0] off);
        reg_attr_t a;
        a = '0;
        case (off)
            24'h00_0000: a = '{1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0}; // scratch 0
            24'h00_0004: a = '{1'b1, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0}; // scratch 1
            24'h00_8000: a = '{1'b1, 3'd2, 1'b1, 1'b1, 1'b1, 1'b1}; // int pending
            24'h00_8004: a = '{1'b1, 3'd3, 1'b1, 1'b1, 1'b1, 1'b1}; // int mask
            24'h00_8010: a = '{1'b1, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0}; // breakpoint 0
            24'h00_8014: a = '{1'b1, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0}; // breakpoint 1
            24'h00_8020: a = '{1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 1'b0}; // control 0
            24'h00_8024: a = '{1'b1, 3'd7, 1'b1, 1'b1, 1'b0, 1'b0}; // control 1 (ro)
            default:     a = '0;
        endcase
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] nv,
                                                input logic [DATA_W-1:0] ov,
                                                input logic [DATA_W-1:0] m);
        return (nv & m) | (ov & ~m);
    endfunction

endpackage

// File: rtl/mmr_decode.sv
module mmr_decode
    import mmr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  mmr_op_e           op,
    input  logic              is_super,
    output logic              in_window,
    output logic [IDX_W-1:0]  idx,
    output logic              refuse
);
    reg_attr_t attr;
    logic      user_space;
    logic      is_atomic;
    logic      type_bad;

    always_comb begin
        attr       = lookup(addr[23:0]);
        in_window  = (addr[31:24] == WIN_TAG);
        user_space = (addr[23:15] == '0);
        is_atomic  = (op == OP_ATMOD) || (op == OP_ATADD);
        type_bad   = ((op == OP_LOAD)  && !attr.can_rd) ||
                     ((op == OP_STORE) && !attr.can_wr) ||
                     (is_atomic        && !attr.can_atomic);
        idx        = attr.idx;
        refuse     = !attr.hit || type_bad ||
                     (!is_super && (!user_space || attr.super_only));
    end
endmodule

// File: rtl/mmr_regfile.sv
module mmr_regfile
    import mmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && (idx == IDX_W'(g)))
                regs[g] <= wr_data;
        end
    end

    assign rd_data = regs[idx];
endmodule

// File: rtl/mmr_access_unit.sv
module mmr_access_unit
    import mmr_pkg::*;
#(
    parameter int              FAST_LAT = 1,
    parameter int              SLOW_LAT = 3,
    parameter logic [NREG-1:0] SLOW_SET = 8'hC0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_op,
    input  logic        req_super,
    input  logic [31:0] req_wdata,
    input  logic [31:0] req_mask,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_fault,
    input  logic        sys_valid,
    output logic        sys_ready,
    input  logic        sys_write,
    input  logic [2:0]  sys_idx,
    input  logic [31:0] sys_wdata,
    input  logic [31:0] sys_mask,
    output logic        sys_rsp_valid,
    output logic [31:0] sys_rdata,
    output logic        ext_req_valid,
    input  logic        ext_req_ready,
    output logic [31:0] ext_addr,
    output logic [1:0]  ext_op,
    output logic [31:0] ext_wdata,
    output logic [31:0] ext_mask,
    input  logic        ext_rsp_valid,
    input  logic [31:0] ext_rdata
);
    localparam int MAX_LAT = (SLOW_LAT > FAST_LAT) ? SLOW_LAT : FAST_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    unit_state_e       state;
    job_t              job;
    logic [CNT_W-1:0]  cnt;
    logic              dec_win;
    logic [IDX_W-1:0]  dec_idx;
    logic              dec_refuse;
    logic [DATA_W-1:0] old_val;
    logic [DATA_W-1:0] new_val;
    logic              done;
    logic              wr_en;

    function automatic logic [CNT_W-1:0] lat_m1(input logic [IDX_W-1:0] i);
        return SLOW_SET[i] ? CNT_W'(SLOW_LAT - 1) : CNT_W'(FAST_LAT - 1);
    endfunction

    mmr_decode u_dec (
        .addr      (req_addr),
        .op        (mmr_op_e'(req_op)),
        .is_super  (req_super),
        .in_window (dec_win),
        .idx       (dec_idx),
        .refuse    (dec_refuse)
    );

    mmr_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .idx     (job.idx),
        .rd_data (old_val),
        .wr_en   (wr_en),
        .wr_data (new_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            job   <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (sys_valid) begin
                        job   <= '{addr: '0, op: (sys_write ? OP_ATMOD : OP_LOAD),
                                   wdata: sys_wdata, mask: sys_mask,
                                   idx: sys_idx, from_sys: 1'b1};
                        cnt   <= lat_m1(sys_idx);
                        state <= ST_BUSY;
                    end else if (req_valid) begin
                        job <= '{addr: req_addr, op: mmr_op_e'(req_op),
                                 wdata: req_wdata, mask: req_mask,
                                 idx: dec_idx, from_sys: 1'b0};
                        cnt <= lat_m1(dec_idx);
                        if (!dec_win)        state <= ST_EXT_REQ;
                        else if (dec_refuse) state <= ST_FAULT;
                        else                 state <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_FAULT:    state <= ST_IDLE;
                ST_EXT_REQ:  if (ext_req_ready) state <= ST_EXT_WAIT;
                ST_EXT_WAIT: if (ext_rsp_valid) state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        done  = (state == ST_BUSY) && (cnt == '0);
        wr_en = done && (job.op != OP_LOAD);
        case (job.op)
            OP_STORE: new_val = job.wdata;
            OP_ATMOD: new_val = merge(job.wdata, old_val, job.mask);
            OP_ATADD: new_val = old_val + job.wdata;
            default:  new_val = old_val;
        endcase
    end

    always_comb begin
        req_ready     = (state == ST_IDLE) && !sys_valid;
        sys_ready     = (state == ST_IDLE);
        rsp_fault     = (state == ST_FAULT);
        rsp_valid     = (done && !job.from_sys) || rsp_fault ||
                        ((state == ST_EXT_WAIT) && ext_rsp_valid);
        rsp_rdata     = '0;
        if (done && !job.from_sys && job.op != OP_STORE)
            rsp_rdata = old_val;
        else if (state == ST_EXT_WAIT && ext_rsp_valid)
            rsp_rdata = ext_rdata;
        sys_rsp_valid = done && job.from_sys;
        sys_rdata     = sys_rsp_valid ? old_val : '0;
        ext_req_valid = (state == ST_EXT_REQ);
        ext_addr      = job.addr;
        ext_op        = job.op;
        ext_wdata     = job.wdata;
        ext_mask      = job.mask;
    end
endmodule

// File: rtl/mmr_access_unit_chk.sv
module mmr_access_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_fault,
    input logic        sys_valid,
    input logic        sys_rsp_valid,
    input logic        ext_req_valid,
    input logic        ext_req_ready,
    input logic [31:0] ext_addr
);
    assert_no_ext_in_window_R1: assert property (@(posedge clk) disable iff (rst)
        ext_req_valid |-> ext_addr[31:24] != 8'hFF);

    assert_ext_hold_R1: assert property (@(posedge clk) disable iff (rst)
        ext_req_valid && !ext_req_ready |=> ext_req_valid && $stable(ext_addr));

    assert_fault_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |=> !rsp_fault);

    assert_fault_zero_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_valid && rsp_rdata == 32'd0);

    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    assert_sys_separate_R9: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && sys_rsp_valid));

    assert_sys_priority_R9: assert property (@(posedge clk) disable iff (rst)
        sys_valid |-> !req_ready);

    assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid && !sys_rsp_valid && !ext_req_valid);
endmodule

bind mmr_access_unit mmr_access_unit_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .rsp_fault     (rsp_fault),
    .sys_valid     (sys_valid),
    .sys_rsp_valid (sys_rsp_valid),
    .ext_req_valid (ext_req_valid),
    .ext_req_ready (ext_req_ready),
    .ext_addr      (ext_addr)
);

// File: tb/mmr_access_unit_test.sv
module mmr_access_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_op = '0;
    logic        req_super = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_mask = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_fault;
    logic        sys_valid = 1'b0;
    logic        sys_ready;
    logic        sys_write = 1'b0;
    logic [2:0]  sys_idx = '0;
    logic [31:0] sys_wdata = '0;
    logic [31:0] sys_mask = '0;
    logic        sys_rsp_valid;
    logic [31:0] sys_rdata;
    logic        ext_req_valid;
    logic        ext_req_ready = 1'b0;
    logic [31:0] ext_addr;
    logic [1:0]  ext_op;
    logic [31:0] ext_wdata;
    logic [31:0] ext_mask;
    logic        ext_rsp_valid = 1'b0;
    logic [31:0] ext_rdata = '0;

    int checks = 0;
    int errors = 0;

    // bus model state
    int          pend = 0;
    int          ext_count = 0;
    logic [31:0] cap_addr = '0;
    logic [31:0] cap_wdata = '0;
    logic [1:0]  cap_op = '0;

    always #10 clk = ~clk;   // 50 MHz

    mmr_access_unit uut (.*);

    always @(negedge clk) begin
        ext_req_ready = 1'b0;
        ext_rsp_valid = 1'b0;
        if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) begin
                ext_rsp_valid = 1'b1;
                ext_rdata     = cap_addr ^ 32'h5A5A_5A5A;
            end
        end else if (ext_req_valid) begin
            ext_req_ready = 1'b1;
            cap_addr  = ext_addr;
            cap_wdata = ext_wdata;
            cap_op    = ext_op;
            ext_count = ext_count + 1;
            pend      = 3;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [31:0] addr, input logic [1:0] op,
                          input logic [31:0] wd, input logic [31:0] mk, input logic sup,
                          output logic [31:0] rd, output logic flt, output int lat);
        @(negedge clk);
        req_addr = addr; req_op = op; req_wdata = wd; req_mask = mk; req_super = sup;
        req_valid = 1'b1;
        for (int i = 0; i < 100; i++) begin
            #5;
            if (req_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0; rd = '0; flt = 1'b0;
        for (int i = 0; i < 100; i++) begin
            lat++;
            #5;
            if (rsp_valid) begin
                rd = rsp_rdata; flt = rsp_fault;
                chk("R8 ready low during response", 32'(req_ready), 32'd0);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic do_sys(input logic [2:0] idx, input logic wr, input logic [31:0] wd,
                          input logic [31:0] mk, output logic [31:0] rd);
        @(negedge clk);
        sys_idx = idx; sys_write = wr; sys_wdata = wd; sys_mask = mk; sys_valid = 1'b1;
        for (int i = 0; i < 100; i++) begin
            #5;
            if (sys_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        sys_valid = 1'b0;
        rd = '0;
        for (int i = 0; i < 100; i++) begin
            #5;
            if (sys_rsp_valid) begin
                rd = sys_rdata;
                chk("R9 sys answer not on main channel", 32'(rsp_valid), 32'd0);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [31:0] rd;
        chk("R10 req_ready after reset", 32'(req_ready), 32'd1);
        chk("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R10 ext_req_valid after reset", 32'(ext_req_valid), 32'd0);
        for (int i = 0; i < 8; i++) begin
            do_sys(3'(i), 1'b0, '0, '0, rd);
            chk("R10 register zero after reset", rd, 32'd0);
        end
    endtask

    task automatic t_user_scratch;
        logic [31:0] rd; logic f; int lat;
        do_req(32'hFF00_0000, 2'd1, 32'h1234_5678, '0, 1'b0, rd, f, lat);
        chk("R2 user store fault", 32'(f), 32'd0);
        chk("R8 store returns zero", rd, 32'd0);
        chk("R8 fast store latency", 32'(lat), 32'd1);
        do_req(32'hFF00_0000, 2'd0, '0, '0, 1'b0, rd, f, lat);
        chk("R2 user load data", rd, 32'h1234_5678);
        chk("R8 fast load latency", 32'(lat), 32'd1);
        do_req(32'hFF00_0004, 2'd1, 32'h0BAD_F00D, '0, 1'b1, rd, f, lat);
        do_req(32'hFF00_0004, 2'd0, '0, '0, 1'b0, rd, f, lat);
        chk("R2 supervisor writes user space", rd, 32'h0BAD_F00D);
    endtask

    task automatic t_privilege;
        logic [31:0] rd; logic f; int lat;
        do_sys(3'd2, 1'b1, 32'h0000_0077, 32'hFFFF_FFFF, rd);
        do_req(32'hFF00_8000, 2'd0, '0, '0, 1'b0, rd, f, lat);
        chk("R2 user load of supervisor reg faults", 32'(f), 32'd1);
        chk("R4 fault returns zero", rd, 32'd0);
        chk("R4 fault latency one", 32'(lat), 32'd1);
        do_req(32'hFF00_8000, 2'd1, 32'hFFFF_FFFF, '0, 1'b0, rd, f, lat);
        chk("R2 user store of supervisor reg faults", 32'(f), 32'd1);
        do_sys(3'd2, 1'b0, '0, '0, rd);
        chk("R4 refused store leaves reg", rd, 32'h0000_0077);
        do_req(32'hFF00_8000, 2'd0, '0, '0, 1'b1, rd, f, lat);
        chk("R2 supervisor load ok", rd, 32'h0000_0077);
        chk("R2 supervisor load no fault", 32'(f), 32'd0);
    endtask

    task automatic t_atmod;
        logic [31:0] rd; logic f; int lat;
        do_req(32'hFF00_8004, 2'd1, 32'hF0F0_F0F0, '0, 1'b1, rd, f, lat);
        do_req(32'hFF00_8004, 2'd2, 32'h0000_FFFF, 32'h00FF_00FF, 1'b1, rd, f, lat);
        chk("R5 atomic modify returns old", rd, 32'hF0F0_F0F0);
        chk("R5 atomic modify no fault", 32'(f), 32'd0);
        do_req(32'hFF00_8004, 2'd0, '0, '0, 1'b1, rd, f, lat);
        chk("R5 atomic modify result", rd, 32'hF000_F0FF);
    endtask

    task automatic t_atadd;
        logic [31:0] rd; logic f; int lat;
        do_req(32'hFF00_8000, 2'd1, 32'd5, '0, 1'b1, rd, f, lat);
        do_req(32'hFF00_8000, 2'd3, 32'hFFFF_FFFF, '0, 1'b1, rd, f, lat);
        chk("R6 atomic add returns old", rd, 32'd5);
        do_req(32'hFF00_8000, 2'd0, '0, '0, 1'b1, rd, f, lat);
        chk("R6 atomic add result wraps", rd, 32'd4);
    endtask

    task automatic t_atomic_refused;
        logic [31:0] rd; logic f; int lat;
        do_req(32'hFF00_0000, 2'd3, 32'd1, '0, 1'b1, rd, f, lat);
        chk("R7 atomic add on scratch faults", 32'(f), 32'd1);
        do_req(32'hFF00_8020, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, rd, f, lat);
        chk("R7 atomic modify on control faults", 32'(f), 32'd1);
        do_req(32'hFF00_0000, 2'd0, '0, '0, 1'b0, rd, f, lat);
        chk("R4 scratch unchanged after refusal", rd, 32'h1234_5678);
    endtask

    task automatic t_access_types;
        logic [31:0] rd; logic f; int lat;
        do_req(32'hFF00_8010, 2'd1, 32'hDEAD_BEEF, '0, 1'b1, rd, f, lat);
        chk("R3 breakpoint store accepted", 32'(f), 32'd0);
        do_req(32'hFF00_8010, 2'd0, '0, '0, 1'b1, rd, f, lat);
        chk("R3 breakpoint load faults", 32'(f), 32'd1);
        chk("R3 breakpoint load returns zero", rd, 32'd0);
        do_sys(3'd4, 1'b0, '0, '0, rd);
        chk("R9 sys reads breakpoint", rd, 32'hDEAD_BEEF);
        do_req(32'hFF00_8024, 2'd1, 32'h1111_1111, '0, 1'b1, rd, f, lat);
        chk("R3 store to read-only faults", 32'(f), 32'd1);
        do_sys(3'd7, 1'b0, '0, '0, rd);
        chk("R4 read-only reg unchanged", rd, 32'd0);
        do_req(32'hFF00_0100, 2'd0, '0, '0, 1'b1, rd, f, lat);
        chk("R3 unmapped offset faults", 32'(f), 32'd1);
        do_req(32'hFF00_0002, 2'd0, '0, '0, 1'b1, rd, f, lat);
        chk("R3 misaligned offset faults", 32'(f), 32'd1);
    endtask

    task automatic t_slow;
        logic [31:0] rd; logic f; int lat;
        do_req(32'hFF00_8020, 2'd1, 32'hCAFE_0001, '0, 1'b1, rd, f, lat);
        chk("R8 slow store latency", 32'(lat), 32'd3);
        do_req(32'hFF00_8020, 2'd0, '0, '0, 1'b1, rd, f, lat);
        chk("R8 slow load latency", 32'(lat), 32'd3);
        chk("R8 slow load data", rd, 32'hCAFE_0001);
    endtask

    task automatic t_sys_write;
        logic [31:0] rd; logic f; int lat;
        do_sys(3'd7, 1'b1, 32'hAAAA_5555, 32'hFFFF_0000, rd);
        chk("R9 sys write returns old", rd, 32'd0);
        do_req(32'hFF00_8024, 2'd0, '0, '0, 1'b1, rd, f, lat);
        chk("R9 sys masked write result", rd, 32'hAAAA_0000);
    endtask

    task automatic t_sys_priority;
        logic [31:0] rd; logic f; int lat;
        // both ask together: sys must be served first, load sees the sys write
        @(negedge clk);
        sys_idx = 3'd1; sys_write = 1'b1; sys_wdata = 32'h0000_00AB; sys_mask = 32'hFFFF_FFFF;
        sys_valid = 1'b1;
        req_addr = 32'hFF00_0004; req_op = 2'd0; req_super = 1'b0; req_valid = 1'b1;
        #5;
        chk("R9 sys wins arbitration", 32'(req_ready), 32'd0);
        @(negedge clk);
        sys_valid = 1'b0;
        req_valid = 1'b0;
        do_req(32'hFF00_0004, 2'd0, '0, '0, 1'b0, rd, f, lat);
        chk("R9 load after sys write", rd, 32'h0000_00AB);
    endtask

    task automatic t_external;
        logic [31:0] rd; logic f; int lat;
        chk("R1 no bus cycle for window accesses", 32'(ext_count), 32'd0);
        do_req(32'h1000_0040, 2'd0, '0, '0, 1'b0, rd, f, lat);
        chk("R1 forwarded address", cap_addr, 32'h1000_0040);
        chk("R1 relayed data", rd, 32'h1000_0040 ^ 32'h5A5A_5A5A);
        chk("R1 relayed no fault", 32'(f), 32'd0);
        do_req(32'hFE00_0008, 2'd1, 32'h7777_0000, '0, 1'b0, rd, f, lat);
        chk("R1 forwarded store data", cap_wdata, 32'h7777_0000);
        chk("R1 forwarded op", 32'(cap_op), 32'd1);
        chk("R1 two bus cycles total", 32'(ext_count), 32'd2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #5;
        t_reset();
        t_user_scratch();
        t_privilege();
        t_atmod();
        t_atadd();
        t_atomic_refused();
        t_access_types();
        t_slow();
        t_sys_write();
        t_sys_priority();
        t_external();
        repeat (3) @(negedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule